// File: doc/BRIEF.md
# Ring-Cascaded FIFO Slice Controller

This block is one slice of a deep first-in, first-out buffer. Several identical slices sit in a ring, each one's expansion output feeding the next one's expansion input, and together they act as one queue whose capacity is the sum of their depths. All slices share one write strobe with its data, and one read strobe. Two tokens move around the ring. The write token names the slice that stores the next word. The read token names the slice that drives the next word out. A word is therefore stored once, in exactly one slice, and never ripples from slice to slice.

A slice hands a token on by pulsing its active-low expansion output for one clock. The pulse comes either when it stores into its highest location or when it pops its highest location. Because both kinds of handoff share that one line, two active-high qualifiers travel with the pulse and say which token moved. The receiving slice owns the token from the next clock edge. The slice's mode is captured while reset is held. An expansion input held low selects a standalone slice that keeps both tokens for good. Otherwise the first-load input picks the one master slice, which starts with both tokens, or a slave, which starts with neither. Composite flags come from an AND of the per-slice active-low flags, and the read buses are ORed, because a slice that is not driving outputs zero.

Top module: `cascade_fifo_slice`

## Requirements
- R1: While `rst_n` is low, the slice captures its mode and forces `xout_n` high with `xout_wr` and `xout_rd` low. After reset, a master (`first_n` low) reports `empty_n` low and `full_n` high. A slave reports both flags high and has `rd_oe` low.
- R2: A write strobe stores `wr_data` only in the slice that holds the write token. Every other slice ignores it.
- R3: Only a slice that holds the read token and has an unread word raises `rd_oe` and drives `rd_data`. Any other slice drives `rd_data` as all zeros, so at most one slice in the ring drives data at a time.
- R4: A write that stores into location DEPTH-1 of a cascaded slice drives `xout_n` low and `xout_wr` high in that same cycle. The slice loses the write token at the next edge, and the next slice gains it at that edge. A strobe in the cycle the pulse arrives still belongs to the sender.
- R5: A read that pops location DEPTH-1 of a cascaded slice drives `xout_n` low and `xout_rd` high in that same cycle, and the read token moves the same way.
- R6: Across the ring, words come out in exactly the order they were written, including across every slice boundary and every wrap of the ring.
- R7: `full_n` is low only while the slice holds the write token and all DEPTH of its locations are unread. A write strobe in that state stores nothing.
- R8: `empty_n` is low only while the slice holds the read token and has no unread word. A read strobe in that state changes nothing, and `rd_oe` stays low.
- R9: A slice whose `xin_n` is low during reset is standalone. It keeps both tokens, wraps its pointers internally, never pulses `xout_n`, and acts as a FIFO of depth DEPTH.
- R10: A read strobe and a write strobe in the same cycle both take effect, with any handoffs they cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the mode is sampled while it is low |
| first_n | input | 1 | Low selects the master slice of a ring |
| xin_n | input | 1 | Expansion input, active-low pulse from the previous slice; low during reset selects standalone |
| xin_wr | input | 1 | Qualifier: the incoming pulse hands over the write token |
| xin_rd | input | 1 | Qualifier: the incoming pulse hands over the read token |
| wr_en | input | 1 | Shared write strobe |
| wr_data | input | WIDTH | Shared write data |
| rd_en | input | 1 | Shared read strobe |
| rd_data | output | WIDTH | Head word while `rd_oe` is high, zero otherwise |
| rd_oe | output | 1 | The slice is driving the read data |
| full_n | output | 1 | Active-low full flag of this slice |
| empty_n | output | 1 | Active-low empty flag of this slice |
| xout_n | output | 1 | Expansion output, active-low one-cycle handoff pulse |
| xout_wr | output | 1 | Qualifier: the outgoing pulse passes the write token |
| xout_rd | output | 1 | Qualifier: the outgoing pulse passes the read token |

## Verification
The properties assume the ring is wired with matching expansion outputs and inputs, that exactly one slice is the master, and that all slices leave reset together. They also assume strobes may come while a flag forbids them, so that the blocking properties are exercised. The stimulus changes inputs only on the falling clock edge. It raises a write strobe only after looking at the composite full flag, and it predicts a pop only when the composite empty flag is high. It also deliberately strobes into a full ring and an empty ring, and it runs back-to-back combined read-and-write cycles that move both tokens across slice boundaries.

// File: rtl/cascade_fifo_pkg.sv
package cascade_fifo_pkg;

  typedef enum logic [1:0] {
    MODE_SOLO   = 2'd0,
    MODE_MASTER = 2'd1,
    MODE_SLAVE  = 2'd2
  } slice_mode_e;

  // Mode picked from the expansion input and first-load level seen during reset.
  function automatic slice_mode_e start_mode(input logic xin_lvl, input logic first_lvl);
    if (!xin_lvl)        return MODE_SOLO;
    else if (!first_lvl) return MODE_MASTER;
    else                 return MODE_SLAVE;
  endfunction

  function automatic logic starts_with_tokens(input slice_mode_e m);
    return (m != MODE_SLAVE);
  endfunction

  // Circular pointer step over a storage of 'depth' entries.
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // Occupancy after one cycle with optional push and pop.
  function automatic int unsigned level_next(input int unsigned lvl, input logic push, input logic pop);
    return lvl + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

endpackage

// File: rtl/slice_token_ctl.sv
module slice_token_ctl
  import cascade_fifo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic first_n,
  input  logic xin_n,
  input  logic xin_wr,
  input  logic xin_rd,
  input  logic wr_hand,
  input  logic rd_hand,
  output logic wr_tok,
  output logic rd_tok,
  output logic solo
);

  slice_mode_e mode_q;
  logic        wr_tok_q, rd_tok_q;
  logic        take_wr, take_rd;

  assign take_wr = !xin_n && xin_wr;
  assign take_rd = !xin_n && xin_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= start_mode(xin_n, first_n);
      wr_tok_q <= starts_with_tokens(start_mode(xin_n, first_n));
      rd_tok_q <= starts_with_tokens(start_mode(xin_n, first_n));
    end else if (mode_q == MODE_SOLO) begin
      wr_tok_q <= 1'b1;
      rd_tok_q <= 1'b1;
    end else begin
      wr_tok_q <= (wr_tok_q && !wr_hand) || take_wr;
      rd_tok_q <= (rd_tok_q && !rd_hand) || take_rd;
    end
  end

  assign wr_tok = wr_tok_q;
  assign rd_tok = rd_tok_q;
  assign solo   = (mode_q == MODE_SOLO);

endmodule

// File: rtl/slice_store.sv
module slice_store
  import cascade_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic             rd_fire,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_word,
  output logic             wr_last,
  output logic             rd_last,
  output logic             is_full,
  output logic             is_empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    level;

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (wr_fire) wr_ptr <= AW'(wrap_inc(32'(wr_ptr), DEPTH));
      if (rd_fire) rd_ptr <= AW'(wrap_inc(32'(rd_ptr), DEPTH));
      level <= CW'(level_next(32'(level), wr_fire, rd_fire));
    end
  end

  assign rd_word  = mem[rd_ptr];
  assign wr_last  = (wr_ptr == AW'(DEPTH - 1));
  assign rd_last  = (rd_ptr == AW'(DEPTH - 1));
  assign is_full  = (level == CW'(DEPTH));
  assign is_empty = (level == '0);

endmodule

// File: rtl/cascade_fifo_slice.sv
module cascade_fifo_slice
  import cascade_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_n,
  input  logic             xin_n,
  input  logic             xin_wr,
  input  logic             xin_rd,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_oe,
  output logic             full_n,
  output logic             empty_n,
  output logic             xout_n,
  output logic             xout_wr,
  output logic             xout_rd
);

  logic             wr_tok, rd_tok, solo;
  logic             st_full, st_empty, wr_last, rd_last;
  logic             wr_fire, rd_fire, wr_hand, rd_hand;
  logic [WIDTH-1:0] rd_word;

  // Named internal events
  assign wr_fire = rst_n && wr_en && wr_tok && !st_full;
  assign rd_fire = rst_n && rd_en && rd_tok && !st_empty;
  assign wr_hand = wr_fire && !solo && wr_last;
  assign rd_hand = rd_fire && !solo && rd_last;

  slice_token_ctl u_tok (
    .clk     (clk),
    .rst_n   (rst_n),
    .first_n (first_n),
    .xin_n   (xin_n),
    .xin_wr  (xin_wr),
    .xin_rd  (xin_rd),
    .wr_hand (wr_hand),
    .rd_hand (rd_hand),
    .wr_tok  (wr_tok),
    .rd_tok  (rd_tok),
    .solo    (solo)
  );

  slice_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_fire  (wr_fire),
    .rd_fire  (rd_fire),
    .wr_data  (wr_data),
    .rd_word  (rd_word),
    .wr_last  (wr_last),
    .rd_last  (rd_last),
    .is_full  (st_full),
    .is_empty (st_empty)
  );

  assign xout_wr = wr_hand;
  assign xout_rd = rd_hand;
  assign xout_n  = !(wr_hand || rd_hand);

  assign full_n  = !(wr_tok && st_full);
  assign empty_n = !(rd_tok && st_empty);
  assign rd_oe   = rd_tok && !st_empty;
  assign rd_data = rd_oe ? rd_word : '0;

endmodule

// File: rtl/cascade_fifo_slice_chk.sv
module cascade_fifo_slice_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic rd_en,
  input logic full_n,
  input logic empty_n,
  input logic rd_oe,
  input logic xout_n,
  input logic xout_wr,
  input logic xout_rd,
  input logic solo
);

  assert_full_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && wr_en && !rd_en) |=> !full_n);

  assert_empty_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && rd_en && !wr_en) |=> !empty_n);

  assert_drive_has_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> empty_n);

  assert_wr_pass_releases_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xout_wr |=> full_n);

  assert_rd_pass_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xout_rd |=> !rd_oe);

  assert_solo_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    solo |-> xout_n);

endmodule

bind cascade_fifo_slice cascade_fifo_slice_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .full_n  (full_n),
  .empty_n (empty_n),
  .rd_oe   (rd_oe),
  .xout_n  (xout_n),
  .xout_wr (xout_wr),
  .xout_rd (xout_rd),
  .solo    (solo)
);

// File: tb/cascade_fifo_slice_tb.sv
`timescale 1ns/100ps
module cascade_fifo_slice_tb;

  localparam int D = 4;
  localparam int W = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [2:0]   xo_n, xo_w, xo_r, fl_n, em_n, oe;
  logic [W-1:0] rd_d [3];

  logic         s_wr = 1'b0, s_rd = 1'b0;
  logic [W-1:0] s_din = '0, s_dout;
  logic         s_oe, s_full_n, s_empty_n, s_xo_n, s_xo_w, s_xo_r;

  logic         comp_full_n, comp_empty_n;
  logic [W-1:0] bus;
  assign comp_full_n  = &fl_n;
  assign comp_empty_n = &em_n;
  assign bus          = rd_d[0] | rd_d[1] | rd_d[2];

  cascade_fifo_slice #(.DEPTH(D), .WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .first_n(1'b0),
    .xin_n(xo_n[2]), .xin_wr(xo_w[2]), .xin_rd(xo_r[2]),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_d[0]), .rd_oe(oe[0]), .full_n(fl_n[0]), .empty_n(em_n[0]),
    .xout_n(xo_n[0]), .xout_wr(xo_w[0]), .xout_rd(xo_r[0]));

  cascade_fifo_slice #(.DEPTH(D), .WIDTH(W)) u_slave1 (
    .clk(clk), .rst_n(rst_n), .first_n(1'b1),
    .xin_n(xo_n[0]), .xin_wr(xo_w[0]), .xin_rd(xo_r[0]),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_d[1]), .rd_oe(oe[1]), .full_n(fl_n[1]), .empty_n(em_n[1]),
    .xout_n(xo_n[1]), .xout_wr(xo_w[1]), .xout_rd(xo_r[1]));

  cascade_fifo_slice #(.DEPTH(D), .WIDTH(W)) u_slave2 (
    .clk(clk), .rst_n(rst_n), .first_n(1'b1),
    .xin_n(xo_n[1]), .xin_wr(xo_w[1]), .xin_rd(xo_r[1]),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_d[2]), .rd_oe(oe[2]), .full_n(fl_n[2]), .empty_n(em_n[2]),
    .xout_n(xo_n[2]), .xout_wr(xo_w[2]), .xout_rd(xo_r[2]));

  cascade_fifo_slice #(.DEPTH(D), .WIDTH(W)) u_solo (
    .clk(clk), .rst_n(rst_n), .first_n(1'b1),
    .xin_n(1'b0), .xin_wr(1'b0), .xin_rd(1'b0),
    .wr_en(s_wr), .wr_data(s_din), .rd_en(s_rd),
    .rd_data(s_dout), .rd_oe(s_oe), .full_n(s_full_n), .empty_n(s_empty_n),
    .xout_n(s_xo_n), .xout_wr(s_xo_w), .xout_rd(s_xo_r));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard queue filled by the driver
  logic [W-1:0] sb [$];

  task automatic ring_cycle(input logic w, input logic [W-1:0] d, input logic r);
    @(negedge clk);
    wr_en = w; wr_data = d; rd_en = r;
    if (w && comp_full_n) sb.push_back(d);
  endtask

  // Monitor: pops and compares at each read that the composite flag allows (R6, R3)
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && rd_en && comp_empty_n) begin
        chk($countones(oe) == 1, "R3 single driver", int'(oe), 1);
        if (sb.size() == 0) chk(1'b0, "R6 unexpected pop", int'(bus), 0);
        else begin
          logic [W-1:0] exp_w;
          exp_w = sb.pop_front();
          chk(bus == exp_w, "R6 R2 ordered word", int'(bus), int'(exp_w));
        end
      end
    end
  end

  // Standalone slice must never pulse its expansion output (R9)
  logic solo_pulsed = 1'b0;
  always @(negedge clk) if (rst_n && !s_xo_n) solo_pulsed = 1'b1;

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic logic [W-1:0] pat(input int i);
    return W'((i * 37 + 5) & 'h1FF);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(xo_n == 3'b111 && xo_w == 3'b000 && xo_r == 3'b000, "R1 xout idle in reset", int'(xo_n), 7);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(em_n == 3'b110, "R1 empty flags", int'(em_n), 6);
    chk(fl_n == 3'b111, "R1 full flags", int'(fl_n), 7);
    chk(oe == 3'b000, "R1 no driver", int'(oe), 0);

    // Fill the ring; check handoff pulses on last-location writes (R4)
    for (int i = 0; i < 3 * D; i++) begin
      ring_cycle(1'b1, pat(i), 1'b0);
      #1;
      if (i == D - 1)
        chk(!xo_n[0] && xo_w[0] && !xo_r[0], "R4 write pass pulse", int'({xo_n[0], xo_w[0]}), 1);
      if (i == D)
        chk(xo_n[1] && xo_n[0], "R4 no pulse mid slice", int'({xo_n[1], xo_n[0]}), 3);
    end
    ring_cycle(1'b0, '0, 1'b0);
    #1;
    chk(!comp_full_n, "R7 composite full", int'(comp_full_n), 0);
    chk(fl_n == 3'b110, "R7 master full with token", int'(fl_n), 6);
    // Write into full ring must be dropped
    ring_cycle(1'b1, 9'h1AA, 1'b0);
    ring_cycle(1'b0, '0, 1'b0);
    #1;
    chk(!comp_full_n, "R7 still full after dropped write", int'(comp_full_n), 0);

    // Drain; check read pass on last-location read (R5)
    for (int i = 0; i < 3 * D; i++) begin
      ring_cycle(1'b0, '0, 1'b1);
      #1;
      if (i == D - 1)
        chk(!xo_n[0] && xo_r[0] && !xo_w[0], "R5 read pass pulse", int'({xo_n[0], xo_r[0]}), 1);
    end
    ring_cycle(1'b0, '0, 1'b0);
    #1;
    chk(!comp_empty_n, "R8 composite empty", int'(comp_empty_n), 0);
    chk(sb.size() == 0, "R6 all words out", sb.size(), 0);
    // Read from empty ring: nothing driven, nothing changes
    ring_cycle(1'b0, '0, 1'b1);
    #1;
    chk(oe == 3'b000 && bus == '0, "R8 empty read drives nothing", int'(bus), 0);
    ring_cycle(1'b0, '0, 1'b0);
    #1;
    chk(!comp_empty_n, "R8 still empty", int'(comp_empty_n), 0);
    ring_cycle(1'b1, 9'h055, 1'b0);
    ring_cycle(1'b0, '0, 1'b1);

    // Simultaneous read and write across slice boundaries (R10)
    ring_cycle(1'b1, pat(100), 1'b0);
    ring_cycle(1'b1, pat(101), 1'b0);
    for (int i = 0; i < 14; i++) ring_cycle(1'b1, pat(200 + i), 1'b1);
    ring_cycle(1'b0, '0, 1'b0);
    #1;
    chk(sb.size() == 2, "R10 level kept by mixed cycles", sb.size(), 2);
    for (int i = 0; i < 2; i++) ring_cycle(1'b0, '0, 1'b1);
    ring_cycle(1'b0, '0, 1'b0);
    #1;
    chk(sb.size() == 0 && !comp_empty_n, "R10 drained", sb.size(), 0);

    // Standalone slice (R9)
    for (int i = 0; i < D; i++) begin
      @(negedge clk); s_wr = 1'b1; s_din = W'(16 + i);
    end
    @(negedge clk); s_wr = 1'b0;
    #1;
    chk(!s_full_n, "R9 solo full", int'(s_full_n), 0);
    @(negedge clk); s_wr = 1'b1; s_din = 9'h1FF;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); s_wr = 1'b0; s_rd = 1'b1;
      #1;
      chk(s_oe && s_dout == W'(16 + i), "R9 solo order", int'(s_dout), 16 + i);
    end
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); s_rd = 1'b0; s_wr = 1'b1; s_din = W'(32 + i);
    end
    begin
      logic [W-1:0] sexp [4];
      sexp[0] = 9'h012; sexp[1] = 9'h013; sexp[2] = 9'h020; sexp[3] = 9'h021;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk); s_wr = 1'b0; s_rd = 1'b1;
        #1;
        chk(s_oe && s_dout == sexp[i], "R9 solo wrap order", int'(s_dout), int'(sexp[i]));
      end
    end
    @(negedge clk); s_rd = 1'b0;
    #1;
    chk(!s_empty_n, "R9 solo empty", int'(s_empty_n), 0);
    chk(!solo_pulsed, "R9 solo never pulses", int'(solo_pulsed), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule